// File: doc/BRIEF.md
# Register-Typed Packed Add/Subtract Unit

This unit adds or subtracts two 32-bit operands as packed lanes. The opcode does not say how wide the lanes are or whether they are signed. Both come from the architectural register number of the operands. That register number falls into one of several banks, and each bank carries a fixed element type: four bytes, two halfwords or one word, each either signed or unsigned.

Four operations are offered: plain add, plain subtract, halving add and halving subtract. A 2-bit mode field chooses between modular and saturating results for plain add and subtract. Register numbers that hold no packed data are rejected, as are reserved modes. A rejected request gives a zero result with the legality flag low.

The arithmetic is combinational. The result and the flag are registered once, so a request on cycle N shows at the outputs after the clock edge that ends cycle N.

Top module: `pkt_alu_top`

## Requirements
- R1: When reg_idx_i is 0 or 1, legal_o is 0 and res_o is 0.
- R2: When mode_i is 2'b10 or 2'b11, legal_o is 0 and res_o is 0. For any register index from 2 to 31 with mode_i[1] = 0, legal_o is 1.
- R3: The lane type is decoded from reg_idx_i as follows: 2..7 gives signed bytes, 8..15 unsigned bytes, 16..23 signed halfwords, 24..29 unsigned halfwords, and 30..31 a single unsigned 32-bit word. Lane i occupies bits [i*W +: W].
- R4: op_i 2'b00 (add) or 2'b01 (subtract) with mode_i 2'b00 gives each lane's result modulo 2^W. No carry or borrow crosses a lane boundary.
- R5: op_i 2'b00 or 2'b01 with mode_i 2'b01 on a signed bank clamps each lane to the range [-2^(W-1), 2^(W-1)-1].
- R6: op_i 2'b00 or 2'b01 with mode_i 2'b01 on an unsigned bank clamps a lane to all-ones when the add overflows and to zero when the subtract underflows.
- R7: op_i 2'b10 (halving add) and 2'b11 (halving subtract) return bits [W:1] of the (W+1)-bit two's-complement sum or difference of the lanes. The lanes are sign-extended on signed banks and zero-extended on unsigned banks.
- R8: For halving operations mode_i[0] has no effect on the result.
- R9: res_o and legal_o are 0 while rst_ni is low. A request shows at the outputs after one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | 00 add, 01 sub, 10 halving add, 11 halving sub |
| mode_i | input | 2 | 00 modular, 01 saturating, 1x reserved |
| reg_idx_i | input | 5 | Register number that selects the lane type |
| opa_i | input | 32 | First packed operand |
| opb_i | input | 32 | Second packed operand |
| res_o | output | 32 | Packed result, registered |
| legal_o | output | 1 | Request legal, registered |

## Verification
The bench builds the unit with its default 32-bit data width, so all three lane widths are instantiated. Every register index from 0 to 31 can then be reached, including the edges of each bank. Directed cases drive lanes to their extreme values (0x80, 0x7F, 0xFF, 0x8000, 0xFFFFFFFF) to force signed and unsigned clamping and carries at lane boundaries. Random requests cover all indices, operations and modes, and each result is compared with a reference model in the bench.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_HADD = 2'b10,
    OP_HSUB = 2'b11
  } pkt_op_e;

  typedef enum logic [1:0] {
    LW_NONE = 2'd0,
    LW_8    = 2'd1,
    LW_16   = 2'd2,
    LW_32   = 2'd3
  } lane_w_e;

  typedef struct packed {
    lane_w_e lw;
    logic    sgn;
  } lane_cfg_t;

  // first register number of each bank; order is behaviour
  localparam int unsigned BANK_SB = 2;
  localparam int unsigned BANK_UB = 8;
  localparam int unsigned BANK_SH = 16;
  localparam int unsigned BANK_UH = 24;
  localparam int unsigned BANK_UW = 30;
endpackage

// File: rtl/pkt_bank_decode.sv
module pkt_bank_decode
  import pkt_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] reg_idx_i,
  output lane_cfg_t        cfg_o
);
  always_comb begin
    cfg_o.lw  = LW_NONE;
    cfg_o.sgn = 1'b0;
    if (32'(reg_idx_i) < BANK_SB) begin
      cfg_o.lw = LW_NONE;
    end else if (32'(reg_idx_i) < BANK_UB) begin
      cfg_o.lw  = LW_8;
      cfg_o.sgn = 1'b1;
    end else if (32'(reg_idx_i) < BANK_SH) begin
      cfg_o.lw = LW_8;
    end else if (32'(reg_idx_i) < BANK_UH) begin
      cfg_o.lw  = LW_16;
      cfg_o.sgn = 1'b1;
    end else if (32'(reg_idx_i) < BANK_UW) begin
      cfg_o.lw = LW_16;
    end else begin
      cfg_o.lw = LW_32;
    end
  end
endmodule

// File: rtl/pkt_lane_alu.sv
module pkt_lane_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  input  logic         sub_i,
  input  logic         halve_i,
  input  logic         sat_i,
  output logic [W-1:0] y_o
);
  logic [W:0] ea, eb, full;
  logic       s_ovf;

  assign ea    = {sgn_i & a_i[W-1], a_i};
  assign eb    = {sgn_i & b_i[W-1], b_i};
  assign full  = sub_i ? (ea - eb) : (ea + eb);
  assign s_ovf = full[W] ^ full[W-1];

  always_comb begin
    y_o = full[W-1:0];
    if (halve_i) begin
      y_o = full[W:1];
    end else if (sat_i) begin
      if (sgn_i) begin
        if (s_ovf) y_o = full[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      end else if (full[W]) begin
        // carry on add -> all ones, borrow on sub -> zero
        y_o = sub_i ? '0 : '1;
      end
    end
  end
endmodule

// File: rtl/pkt_lane_array.sv
module pkt_lane_array #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sgn_i,
  input  logic              sub_i,
  input  logic              halve_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int N_LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    pkt_lane_alu #(.W(LANE_W)) u_lane (
      .a_i    (a_i[i*LANE_W +: LANE_W]),
      .b_i    (b_i[i*LANE_W +: LANE_W]),
      .sgn_i  (sgn_i),
      .sub_i  (sub_i),
      .halve_i(halve_i),
      .sat_i  (sat_i),
      .y_o    (y_o[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/pkt_alu_top.sv
module pkt_alu_top
  import pkt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o,
  output logic              legal_o
);
  lane_cfg_t         cfg;
  logic              sub, halve, sat, legal_d;
  logic [DATA_W-1:0] y8, y16, y32, sel;

  pkt_bank_decode #(.IDX_W(IDX_W)) u_dec (
    .reg_idx_i(reg_idx_i),
    .cfg_o    (cfg)
  );

  assign sub     = op_i[0];
  assign halve   = op_i[1];
  assign sat     = (mode_i == 2'b01) && !halve;
  assign legal_d = (cfg.lw != LW_NONE) && !mode_i[1];

  pkt_lane_array #(.DATA_W(DATA_W), .LANE_W(8)) u_b (
    .a_i(opa_i), .b_i(opb_i), .sgn_i(cfg.sgn), .sub_i(sub),
    .halve_i(halve), .sat_i(sat), .y_o(y8)
  );
  pkt_lane_array #(.DATA_W(DATA_W), .LANE_W(16)) u_h (
    .a_i(opa_i), .b_i(opb_i), .sgn_i(cfg.sgn), .sub_i(sub),
    .halve_i(halve), .sat_i(sat), .y_o(y16)
  );
  pkt_lane_array #(.DATA_W(DATA_W), .LANE_W(32)) u_w (
    .a_i(opa_i), .b_i(opb_i), .sgn_i(cfg.sgn), .sub_i(sub),
    .halve_i(halve), .sat_i(sat), .y_o(y32)
  );

  always_comb begin
    unique case (cfg.lw)
      LW_8:    sel = y8;
      LW_16:   sel = y16;
      LW_32:   sel = y32;
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      legal_o <= 1'b0;
    end else begin
      res_o   <= legal_d ? sel : '0;
      legal_o <= legal_d;
    end
  end
endmodule

// File: rtl/pkt_alu_chk.sv
module pkt_alu_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        op_i,
  input logic [1:0]        mode_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] res_o,
  input logic              legal_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R1 / R2: rejected request gives zero
  a_r1_illegal_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_o |-> res_o == '0);

  a_r1_low_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(32'(reg_idx_i) < 2) |-> !legal_o);

  a_r2_reserved_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(mode_i[1]) |-> !legal_o);

  a_r2_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(32'(reg_idx_i) >= 2 && !mode_i[1]) |-> legal_o);

  // R6: unsigned saturating word add never falls below either operand
  a_r6_uw_sat_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(32'(reg_idx_i) >= 30 && op_i == 2'b00 && mode_i == 2'b01)
    |-> res_o >= $past(opa_i) && res_o >= $past(opb_i));

  // R6: unsigned saturating word sub never exceeds the minuend
  a_r6_uw_sat_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(32'(reg_idx_i) >= 30 && op_i == 2'b01 && mode_i == 2'b01)
    |-> res_o <= $past(opa_i));

  // R9: outputs held at zero in reset
  always_comb begin
    if (!rst_ni) a_r9_reset: assert (res_o == '0 && !legal_o);
  end
endmodule

bind pkt_alu_top pkt_alu_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .mode_i   (mode_i),
  .reg_idx_i(reg_idx_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .res_o    (res_o),
  .legal_o  (legal_o)
);

// File: tb/sim_pkt_alu_top.sv
module sim_pkt_alu_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = '0;
  logic [1:0]  mode_i = '0;
  logic [4:0]  reg_idx_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [31:0] res_o;
  logic        legal_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  pkt_alu_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .mode_i(mode_i),
    .reg_idx_i(reg_idx_i), .opa_i(opa_i), .opb_i(opb_i),
    .res_o(res_o), .legal_o(legal_o)
  );

  function automatic logic [31:0] lane_ref(int w, bit sgn, logic [1:0] op, logic [1:0] mode,
                                           logic [31:0] a, logic [31:0] b);
    logic signed [35:0] ea, eb, full, lo, hi, mask;
    mask = (36'sd1 <<< w) - 1;
    ea = $signed({4'b0, a}); eb = $signed({4'b0, b});
    if (sgn && a[w-1]) ea = ea - (36'sd1 <<< w);
    if (sgn && b[w-1]) eb = eb - (36'sd1 <<< w);
    full = op[0] ? ea - eb : ea + eb;
    if (op[1]) full = full >>> 1;
    else if (mode == 2'b01) begin
      lo = sgn ? -(36'sd1 <<< (w-1)) : 36'sd0;
      hi = sgn ? (36'sd1 <<< (w-1)) - 1 : mask;
      if (full < lo) full = lo;
      if (full > hi) full = hi;
    end
    return 32'(full & mask);
  endfunction

  function automatic logic [32:0] model(logic [1:0] op, logic [1:0] mode, logic [4:0] idx,
                                        logic [31:0] a, logic [31:0] b);
    int w; bit sgn; logic [31:0] r, m;
    if (idx < 2 || mode[1]) return 33'd0;
    if (idx < 8)       begin w = 8;  sgn = 1; end
    else if (idx < 16) begin w = 8;  sgn = 0; end
    else if (idx < 24) begin w = 16; sgn = 1; end
    else if (idx < 30) begin w = 16; sgn = 0; end
    else               begin w = 32; sgn = 0; end
    r = '0;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    for (int i = 0; i < 32 / w; i++)
      r |= lane_ref(w, sgn, op, mode, (a >> (i*w)) & m, (b >> (i*w)) & m) << (i*w);
    return {1'b1, r};
  endfunction

  task automatic check(string req, logic [32:0] got, logic [32:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got legal=%0b res=%08h, expected legal=%0b res=%08h",
               req, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic run(string req, logic [1:0] op, logic [1:0] mode, logic [4:0] idx,
                     logic [31:0] a, logic [31:0] b);
    @(negedge clk_i);
    op_i = op; mode_i = mode; reg_idx_i = idx; opa_i = a; opb_i = b;
    @(negedge clk_i);
    check(req, {legal_o, res_o}, model(op, mode, idx, a, b));
  endtask

  // explicit literal expectation, independent of the model
  task automatic run_lit(string req, logic [1:0] op, logic [1:0] mode, logic [4:0] idx,
                         logic [31:0] a, logic [31:0] b, logic [32:0] exp);
    @(negedge clk_i);
    op_i = op; mode_i = mode; reg_idx_i = idx; opa_i = a; opb_i = b;
    @(negedge clk_i);
    check(req, {legal_o, res_o}, exp);
  endtask

  initial begin
    void'($urandom(32'd1234));
    op_i = 2'b00; mode_i = 2'b00; reg_idx_i = 5'd2; opa_i = 32'h0101_0101; opb_i = 32'h0101_0101;
    #23;
    check("R9 reset", {legal_o, res_o}, 33'd0);
    rst_ni = 1'b1;

    run_lit("R1 idx0", 2'b00, 2'b00, 5'd0, 32'h1234_5678, 32'h1111_1111, 33'd0);
    run_lit("R1 idx1", 2'b01, 2'b01, 5'd1, 32'hFFFF_FFFF, 32'h1, 33'd0);
    run_lit("R2 mode10", 2'b00, 2'b10, 5'd9, 32'h1, 32'h1, 33'd0);
    run_lit("R2 mode11", 2'b00, 2'b11, 5'd30, 32'h1, 32'h1, 33'd0);
    run_lit("R4 byte wrap", 2'b00, 2'b00, 5'd8, 32'hFF80_7F01, 32'h0180_01FF, {1'b1, 32'h0000_8000});
    run_lit("R4 half sub wrap", 2'b01, 2'b00, 5'd16, 32'h0000_0005, 32'h0001_0006, {1'b1, 32'hFFFF_FFFF});
    run_lit("R5 sb sat add", 2'b00, 2'b01, 5'd2, 32'h7F80_7F10, 32'h01FF_0110, {1'b1, 32'h7F80_7F20});
    run_lit("R5 sh sat sub", 2'b01, 2'b01, 5'd23, 32'h8000_7FFF, 32'h0001_FFFF, {1'b1, 32'h8000_7FFF});
    run_lit("R6 ub sat add", 2'b00, 2'b01, 5'd15, 32'hFF10_8001, 32'h0120_8001, {1'b1, 32'hFF30_FF02});
    run_lit("R6 uh sat sub", 2'b01, 2'b01, 5'd24, 32'h0001_0009, 32'h0002_0003, {1'b1, 32'h0000_0006});
    run_lit("R6 uw sat add", 2'b00, 2'b01, 5'd31, 32'hFFFF_FFF0, 32'h20, {1'b1, 32'hFFFF_FFFF});
    run_lit("R7 sb hadd", 2'b10, 2'b00, 5'd7, 32'h8080_0301, 32'h80FF_0301, {1'b1, 32'h80BF_0301});
    run_lit("R7 ub hadd", 2'b10, 2'b00, 5'd10, 32'hFFFF_0000, 32'hFF01_0000, {1'b1, 32'hFF80_0000});
    run_lit("R7 uh hsub", 2'b11, 2'b00, 5'd29, 32'h0000_0008, 32'h0001_0002, {1'b1, 32'hFFFF_0003});
    run_lit("R8 hadd mode01", 2'b10, 2'b01, 5'd7, 32'h8080_0301, 32'h80FF_0301, {1'b1, 32'h80BF_0301});
    run_lit("R3 word sub", 2'b01, 2'b00, 5'd30, 32'h0000_0000, 32'h0000_0001, {1'b1, 32'hFFFF_FFFF});
    for (int i = 0; i < 32; i++)
      run("R3 bank sweep", 2'b00, 2'b01, 5'(i), 32'h7FFF_80FF, 32'h7F01_8001);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = $urandom(); b = $urandom();
      if (i % 4 == 0) a = a | 32'h8080_8080;
      run("R4 R5 R6 R7 R8 random", 2'($urandom()), 2'($urandom()), 5'($urandom()), a, b);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule